// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for a dual-slope integrating analog-to-digital converter. A prescaler divides the master clock into a count clock. On each count the controller advances a four-phase conversion cycle and drives one switch-enable output per phase. The phases are integrator zeroing, auto zero, signal integration and reference deintegration. The analog integrator, the switches and the comparator sit outside the block. The comparator reports whether the integrator output is still above zero, and it reaches the controller through a two-flop synchronizer.

The signal integration phase has a fixed length. Deintegration stops when the comparator shows the integrator has crossed zero, or when a count ceiling is reached. The number of deintegration counts becomes the conversion result, and an overrange flag is raised when that number exceeds full scale. A free-running frame counter gives every conversion frame the same total length. Auto zero absorbs whatever time deintegration and zeroing left unused. While the hold input is high, the latched result and the flag stay frozen.

The states are ZERO (integrator output zero), AUTOZ (auto zero), INTEG (signal integrate) and DEINT (reference deintegrate). Their transitions are:
- ZERO→AUTOZ, taken when the synchronized comparator is low or the zeroing ceiling is reached.
- AUTOZ→INTEG, taken when the frame counter reaches its last count.
- INTEG→DEINT, taken after the fixed integration count.
- DEINT→ZERO, taken when the synchronized comparator is low or the deintegration ceiling is reached.

Top module: `dslope_seq`

## Requirements
- R1: The state, and therefore every phase output, changes only on a count tick. A count tick occurs once every DIV master clocks, on rising edges DIV, 2·DIV, … after reset is released.
- R2: Exactly one of ph_zi, ph_az, ph_int, ph_deint is high at all times. The phases always follow the order ZERO→AUTOZ→INTEG→DEINT→ZERO.
- R3: INTEG lasts exactly INT_COUNTS counts.
- R4: At each tick in DEINT, the controller samples the comparator after its two synchronizer flops. DEINT ends at the first tick that sees it low. The result is the number of counts in DEINT before that tick, so DEINT lasts result+1 counts.
- R5: If the comparator never goes low, DEINT ends after DEINT_MAX+1 counts and the result is DEINT_MAX.
- R6: overrange is 1 exactly when the latched result is greater than FULL_SCALE.
- R7: ZERO ends at the first tick that sees the synchronized comparator low. It ends after at most ZERO_MAX+1 counts even if no crossing is seen.
- R8: From one INTEG start to the next is exactly FRAME_COUNTS counts. AUTOZ fills the remainder. The first INTEG after reset starts FRAME_COUNTS counts after reset release.
- R9: While hold is high at the end of DEINT, result and overrange keep their previous values.
- R10: Active-high synchronous reset gives ph_zi=1, the other phase outputs 0, result=0 and overrange=0, and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Comparator: 1 while the integrator is above zero |
| hold | input | 1 | Freezes the latched result and overrange |
| ph_zi | output | 1 | Integrator-zero switch enable |
| ph_az | output | 1 | Auto-zero switch enable |
| ph_int | output | 1 | Signal-integrate switch enable |
| ph_deint | output | 1 | Reference-deintegrate switch enable |
| result | output | RW | Latched deintegration count |
| overrange | output | 1 | Latched result exceeds full scale |

## Verification
Phase outputs change on the master-clock edge that carries a count tick. The bench therefore counts edges since reset release and treats every DIV-th edge as a tick, checking phases, durations and stability at the falling edge after each edge. A comparator level that the bench drives after tick m crosses the two synchronizer flops within two clocks, and the controller first acts on it at tick m+1; the bench's integrator model is built on exactly that one-count lag. result and overrange are due on the same edge that leaves DEINT, so they are compared at the falling edge where ph_zi is first seen high again.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
    typedef enum logic [1:0] {
        PH_ZERO  = 2'd0,
        PH_AUTOZ = 2'd1,
        PH_INTEG = 2'd2,
        PH_DEINT = 2'd3
    } phase_e;
endpackage

// File: rtl/dslope_prescale.sv
module dslope_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dslope_sync.sv
module dslope_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
    import dslope_pkg::*;
#(
    parameter int INT_COUNTS   = 1000,
    parameter int DEINT_MAX    = 2090,
    parameter int ZERO_MAX     = 640,
    parameter int FRAME_COUNTS = 4000,
    parameter int RW           = $clog2(DEINT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          cmp_hi,
    output logic          zi_en,
    output logic          az_en,
    output logic          int_en,
    output logic          deint_en,
    output logic          conv_done,
    output logic [RW-1:0] conv_cnt
);
    localparam int PMAX0 = (INT_COUNTS - 1 > DEINT_MAX) ? INT_COUNTS - 1 : DEINT_MAX;
    localparam int PMAX  = (PMAX0 > ZERO_MAX) ? PMAX0 : ZERO_MAX;
    localparam int PW    = $clog2(PMAX + 1);
    localparam int FW    = $clog2(FRAME_COUNTS);
    localparam logic [PW-1:0] INT_LAST   = PW'(INT_COUNTS - 1);
    localparam logic [PW-1:0] DEINT_LAST = PW'(DEINT_MAX);
    localparam logic [PW-1:0] ZERO_LAST  = PW'(ZERO_MAX);
    localparam logic [FW-1:0] FR_LAST    = FW'(FRAME_COUNTS - 1);

    phase_e        state, nxt;
    logic [PW-1:0] ph_cnt;
    logic [FW-1:0] fr_cnt;

    // next-state decision, consumed only on a tick
    always_comb begin
        nxt = state;
        unique case (state)
            PH_ZERO:  if (!cmp_hi || ph_cnt == ZERO_LAST)  nxt = PH_AUTOZ;
            PH_AUTOZ: if (fr_cnt == FR_LAST)               nxt = PH_INTEG;
            PH_INTEG: if (ph_cnt == INT_LAST)              nxt = PH_DEINT;
            PH_DEINT: if (!cmp_hi || ph_cnt == DEINT_LAST) nxt = PH_ZERO;
        endcase
    end

    // state register and the counters that advance with it
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PH_ZERO;
            ph_cnt <= '0;
            fr_cnt <= '0;
        end else if (tick) begin
            state  <= nxt;
            ph_cnt <= (nxt != state) ? '0 : ph_cnt + 1'b1;
            fr_cnt <= (fr_cnt == FR_LAST) ? '0 : fr_cnt + 1'b1;
        end
    end

    // switch enables decoded from the registered state
    always_comb begin
        zi_en    = 1'b0;
        az_en    = 1'b0;
        int_en   = 1'b0;
        deint_en = 1'b0;
        unique case (state)
            PH_ZERO:  zi_en    = 1'b1;
            PH_AUTOZ: az_en    = 1'b1;
            PH_INTEG: int_en   = 1'b1;
            PH_DEINT: deint_en = 1'b1;
        endcase
    end

    assign conv_done = tick && (state == PH_DEINT) && (nxt == PH_ZERO);
    assign conv_cnt  = RW'(ph_cnt);
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
    parameter int DIV          = 4,
    parameter int INT_COUNTS   = 1000,
    parameter int FULL_SCALE   = 2000,
    parameter int DEINT_MAX    = 2090,
    parameter int ZERO_MAX     = 640,
    parameter int FRAME_COUNTS = 4000,
    parameter int SYNC_STAGES  = 2,
    parameter int RW           = $clog2(DEINT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp_in,
    input  logic          hold,
    output logic          ph_zi,
    output logic          ph_az,
    output logic          ph_int,
    output logic          ph_deint,
    output logic [RW-1:0] result,
    output logic          overrange
);
    localparam logic [RW-1:0] FULL_LIM = RW'(FULL_SCALE);

    logic          tick;
    logic          cmp_s;
    logic          conv_done;
    logic [RW-1:0] conv_cnt;

    dslope_prescale #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_in),
        .q   (cmp_s)
    );

    dslope_fsm #(
        .INT_COUNTS   (INT_COUNTS),
        .DEINT_MAX    (DEINT_MAX),
        .ZERO_MAX     (ZERO_MAX),
        .FRAME_COUNTS (FRAME_COUNTS),
        .RW           (RW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cmp_hi    (cmp_s),
        .zi_en     (ph_zi),
        .az_en     (ph_az),
        .int_en    (ph_int),
        .deint_en  (ph_deint),
        .conv_done (conv_done),
        .conv_cnt  (conv_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            overrange <= 1'b0;
        end else if (conv_done && !hold) begin
            result    <= conv_cnt;
            overrange <= (conv_cnt > FULL_LIM);
        end
    end
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
    parameter int INT_COUNTS = 1000,
    parameter int FULL_SCALE = 2000,
    parameter int RW         = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          hold,
    input logic          ph_zi,
    input logic          ph_az,
    input logic          ph_int,
    input logic          ph_deint,
    input logic [RW-1:0] result,
    input logic          overrange
);
    localparam int       CW       = $clog2(INT_COUNTS + 1);
    localparam logic [CW-1:0] INT_EXP  = CW'(INT_COUNTS);
    localparam logic [RW-1:0] FULL_LIM = RW'(FULL_SCALE);

    logic [CW-1:0] int_ticks;

    always_ff @(posedge clk) begin
        if (rst || !ph_int) int_ticks <= '0;
        else if (tick)      int_ticks <= int_ticks + 1'b1;
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({ph_zi, ph_az, ph_int, ph_deint}) == 1);

    p_tick_only_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable({ph_zi, ph_az, ph_int, ph_deint}));

    p_order_az_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_az) |-> $past(ph_zi));

    p_order_int_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_int) |-> $past(ph_az));

    p_order_deint_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_deint) |-> $past(ph_int));

    p_order_zi_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_zi) |-> $past(ph_deint));

    p_int_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_int) |-> (int_ticks == INT_EXP));

    p_ovr_r6: assert property (@(posedge clk) disable iff (rst)
        overrange == (result > FULL_LIM));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(result) && $stable(overrange)));

    p_latch_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> ($past(ph_deint) && ph_zi));
endmodule

bind dslope_seq dslope_seq_chk #(
    .INT_COUNTS (INT_COUNTS),
    .FULL_SCALE (FULL_SCALE),
    .RW         (RW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .hold      (hold),
    .ph_zi     (ph_zi),
    .ph_az     (ph_az),
    .ph_int    (ph_int),
    .ph_deint  (ph_deint),
    .result    (result),
    .overrange (overrange)
);

// File: tb/tb_dslope_seq.sv
module tb_dslope_seq;
    localparam int DIV   = 4;
    localparam int INTC  = 10;
    localparam int FULL  = 20;
    localparam int DMAX  = 22;
    localparam int ZMAX  = 15;
    localparam int FRAME = 60;
    localparam int RW    = $clog2(DMAX + 1);
    localparam int REF   = 5;
    localparam int ZRATE = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp_in = 1'b0;
    logic hold = 1'b0;
    logic ph_zi, ph_az, ph_int, ph_deint;
    logic [RW-1:0] result;
    logic overrange;

    always #2 clk = ~clk;

    dslope_seq #(
        .DIV(DIV), .INT_COUNTS(INTC), .FULL_SCALE(FULL), .DEINT_MAX(DMAX),
        .ZERO_MAX(ZMAX), .FRAME_COUNTS(FRAME), .SYNC_STAGES(2), .RW(RW)
    ) dut (
        .clk(clk), .rst(rst), .cmp_in(cmp_in), .hold(hold),
        .ph_zi(ph_zi), .ph_az(ph_az), .ph_int(ph_int), .ph_deint(ph_deint),
        .result(result), .overrange(overrange)
    );

    int total = 0;
    int bad = 0;
    bit go = 0;
    bit done = 0;
    int k = 0;
    int vin_cur = 0;

    always @(posedge clk) begin
        if (rst) k <= 0;
        else     k <= k + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int cur_ph();
        if (ph_zi)    return 0;
        if (ph_az)    return 1;
        if (ph_int)   return 2;
        if (ph_deint) return 3;
        return -1;
    endfunction

    // comparator model and per-phase checks
    initial begin
        int prev, cur, dur, integ, vin_int;
        int zi_dur, deint_dur, exp_zi, last_res, last_ovr;
        bit first;
        prev = 0; dur = 0; integ = 0; vin_int = 0;
        zi_dur = 0; deint_dur = 0; exp_zi = 1; last_res = 0; last_ovr = 0;
        first = 1;
        wait (go);
        forever begin
            @(negedge clk);
            cur = cur_ph();
            chk($countones({ph_zi, ph_az, ph_int, ph_deint}) == 1, "R2 onehot", cur, prev);
            if (k > 0 && (k % DIV) == 0) begin
                case (prev)
                    0: integ = integ - ZRATE;
                    1: integ = 0;
                    2: integ = integ + vin_int;
                    default: integ = integ - REF;
                endcase
                cmp_in = (integ > 0);
                dur++;
                if (cur != prev) begin
                    chk(cur == (prev + 1) % 4, "R2 order", cur, (prev + 1) % 4);
                    case (prev)
                        0: begin
                            chk(dur == exp_zi, "R7 zero length", dur, exp_zi);
                            zi_dur = dur;
                        end
                        1: begin
                            int exp_az;
                            exp_az = first ? FRAME - zi_dur : FRAME - INTC - deint_dur - zi_dur;
                            chk(dur == exp_az, "R8 frame fill", dur, exp_az);
                            first = 0;
                            vin_int = vin_cur;
                        end
                        2: chk(dur == INTC, "R3 integrate length", dur, INTC);
                        default: begin
                            int q, c, res, rz, eo;
                            q = INTC * vin_int;
                            c = (q + REF - 1) / REF;
                            res = (c > DMAX) ? DMAX : c;
                            chk(dur == res + 1, (res == DMAX) ? "R5 deint timeout" : "R4 deint length",
                                dur, res + 1);
                            deint_dur = dur;
                            eo = (res > FULL) ? 1 : 0;
                            if (hold) begin
                                chk(int'(result) == last_res, "R9 hold result", int'(result), last_res);
                                chk(int'(overrange) == last_ovr, "R9 hold overrange", int'(overrange), last_ovr);
                            end else begin
                                chk(int'(result) == res, (res == DMAX) ? "R5 result" : "R4 result",
                                    int'(result), res);
                                chk(int'(overrange) == eo, "R6 overrange", int'(overrange), eo);
                                last_res = res;
                                last_ovr = eo;
                            end
                            rz = q - (res + 1) * REF;
                            if (rz <= 0) exp_zi = 1;
                            else begin
                                exp_zi = (rz + ZRATE - 1) / ZRATE + 1;
                                if (exp_zi > ZMAX + 1) exp_zi = ZMAX + 1;
                            end
                        end
                    endcase
                    dur = 0;
                end
            end else begin
                chk(cur == prev, "R1 change off tick", cur, prev);
            end
            prev = cur;
        end
    end

    // stimulus
    initial begin
        repeat (5) @(negedge clk);
        chk(ph_zi == 1'b1, "R10 reset zi", int'(ph_zi), 1);
        chk({ph_az, ph_int, ph_deint} == 3'b000, "R10 reset others",
            int'({ph_az, ph_int, ph_deint}), 0);
        chk(result == '0, "R10 reset result", int'(result), 0);
        chk(overrange == 1'b0, "R10 reset overrange", int'(overrange), 0);
        rst = 1'b0;
        go = 1'b1;
        for (int v = 0; v <= 20; v++) begin
            while (!ph_az) @(negedge clk);
            vin_cur = v;
            while (ph_az) @(negedge clk);
        end
        // R9: freeze across two conversions, then release
        while (!ph_az) @(negedge clk);
        vin_cur = 5; hold = 1'b1;
        while (ph_az) @(negedge clk);
        while (!ph_az) @(negedge clk);
        vin_cur = 7;
        while (ph_az) @(negedge clk);
        while (!ph_az) @(negedge clk);
        hold = 1'b0;
        while (ph_az) @(negedge clk);
        while (!ph_az) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule